// File: doc/BRIEF.md
# Next-Secret Update Sequencer

This block runs the "replace the secret" command of a secure-memory slave at byte level. When the bus layer presents the matching command byte and the protected area is writable, the block starts an external hash unit. The hash unit reads the scratchpad bytes that are already present as part of its input. When the result returns, the block writes it into the secret register. It then overwrites every scratchpad byte with a fixed fill value. For the rest of the transaction it answers each read slot with a status bit.

A successful update answers with bits that alternate between 0 and 1. A refused update answers with zeros. An update that times out also answers with zeros. The status stream continues until the bus layer signals a bus reset. A bus reset at any point returns the block to idle. It also suppresses any secret or scratchpad write that would happen in the same cycle. The hash core, the physical bus layer and supply monitoring are outside this block.

Top module: `nsec_seq`

## Requirements
- R1: After reset, busy, hash_start, sec_we, sp_we and rd_bit are all 0.
- R2: Only a command strobe carrying CMD_NEXT (default 8'h33) while idle starts the sequence. Any other byte, and any command during an active or finished sequence, has no effect on busy, hash_start or rd_bit.
- R3: If wr_prot is 1 when the command is accepted, hash_start, busy, sec_we and sp_we all stay 0. Every read slot then returns rd_bit 0 until bus_rst.
- R4: When the command is accepted with wr_prot at 0, hash_start is 1 for exactly the following cycle (hash cycle 0), and busy rises in that same cycle.
- R5: If hash_done arrives in hash cycle n, for any n from 0 to TIMEOUT_CYC-1, sec_we is 1 in that cycle and sec_wdata equals hash_result.
- R6: If hash_done has not arrived by hash cycle TIMEOUT_CYC-1, no secret write happens and busy falls. Every read slot then returns rd_bit 0 until bus_rst.
- R7: Starting the cycle after the secret write, sp_we is 1 for SP_BYTES consecutive cycles. sp_addr runs from 0 up to SP_BYTES-1, and sp_wdata is FILL_BYTE (default 8'hAA).
- R8: busy stays 1 from hash cycle 0 through the last fill write and is 0 in the cycle that follows.
- R9: After a successful fill, rd_bit is 0 before the first read slot and inverts on the cycle after each rd_slot. Read slot k therefore sees k mod 2.
- R10: bus_rst returns the block to idle on the next cycle, with busy and rd_bit at 0. sec_we and sp_we are 0 in any cycle where bus_rst is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| bus_rst | input | 1 | Bus reset pulse seen by the bus layer |
| wr_prot | input | 1 | The secret area is write-protected |
| hash_start | output | 1 | Single-cycle start request to the hash unit |
| hash_done | input | 1 | Hash result valid |
| hash_result | input | SECRET_W | Hash result |
| sec_we | output | 1 | Secret register write enable |
| sec_wdata | output | SECRET_W | Secret register write data |
| sp_we | output | 1 | Scratchpad byte write enable |
| sp_addr | output | $clog2(SP_BYTES) | Scratchpad byte address |
| sp_wdata | output | 8 | Scratchpad byte write data |
| rd_slot | input | 1 | Read slot strobe from the bus layer |
| rd_bit | output | 1 | Status bit returned in the current read slot |
| busy | output | 1 | Hash or refill in progress |

## Verification
hash_start, busy and the secret write are combinational in the hash state. They are therefore checked in the cycle the stimulus is applied, or one edge after the command. The fill writes are checked on each of the SP_BYTES cycles after the secret write. rd_bit is checked before each slot strobe, and it moves one edge after that strobe. The bench drives inputs on the falling edge and samples 1 ns later, so each check falls inside the one cycle whose value it predicts. The bench sweeps the hash-done arrival over every allowed cycle, sweeps all 256 command bytes, and places bus resets inside the hash and fill phases.

// File: rtl/nsec_pkg.sv
package nsec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HASH = 3'd1,
    ST_FILL = 3'd2,
    ST_DONE = 3'd3,
    ST_FAIL = 3'd4
  } nsec_state_e;
endpackage

// File: rtl/nsec_rst_sync.sv
module nsec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_ni <= meta_q;
    end
  end
endmodule

// File: rtl/nsec_timer.sv
module nsec_timer #(
  parameter int unsigned LIMIT = 400000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic run,
  output logic first,
  output logic expired
);
  localparam int unsigned TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) cnt_d = '0;
    else if (!expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end

  assign first   = run && (cnt_q == '0);
  assign expired = run && (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/nsec_fill.sv
module nsec_fill #(
  parameter int unsigned SP_BYTES = 8
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        run,
  output logic [$clog2(SP_BYTES)-1:0] addr,
  output logic                        last
);
  localparam int unsigned AW = $clog2(SP_BYTES);

  logic [AW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = run ? idx_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else idx_q <= idx_d;
  end

  assign addr = idx_q;
  assign last = run && (idx_q == AW'(SP_BYTES - 1));
endmodule

// File: rtl/nsec_status.sv
module nsec_status (
  input  logic clk,
  input  logic rst_ni,
  input  logic run,
  input  logic slot,
  output logic phase
);
  logic ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (!run) ph_d = 1'b0;
    else if (slot) ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else ph_q <= ph_d;
  end

  assign phase = ph_q;
endmodule

// File: rtl/nsec_seq.sv
module nsec_seq
  import nsec_pkg::*;
#(
  parameter int unsigned SECRET_W    = 32,
  parameter int unsigned SP_BYTES    = 8,
  parameter logic [7:0]  FILL_BYTE   = 8'hAA,
  parameter logic [7:0]  CMD_NEXT    = 8'h33,
  parameter int unsigned TIMEOUT_CYC = 400000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [7:0]                  cmd_byte,
  input  logic                        bus_rst,
  input  logic                        wr_prot,
  output logic                        hash_start,
  input  logic                        hash_done,
  input  logic [SECRET_W-1:0]         hash_result,
  output logic                        sec_we,
  output logic [SECRET_W-1:0]         sec_wdata,
  output logic                        sp_we,
  output logic [$clog2(SP_BYTES)-1:0] sp_addr,
  output logic [7:0]                  sp_wdata,
  input  logic                        rd_slot,
  output logic                        rd_bit,
  output logic                        busy
);
  nsec_state_e state_q, state_d;
  logic rst_ni;
  logic in_hash, in_fill, in_done;
  logic t_first, t_expired, f_last, phase;
  logic cmd_hit;

  nsec_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ni(rst_ni));

  assign in_hash = (state_q == ST_HASH);
  assign in_fill = (state_q == ST_FILL);
  assign in_done = (state_q == ST_DONE);
  assign cmd_hit = cmd_valid && (cmd_byte == CMD_NEXT);

  nsec_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_ni(rst_ni), .run(in_hash),
    .first(t_first), .expired(t_expired)
  );

  nsec_fill #(.SP_BYTES(SP_BYTES)) u_fill (
    .clk(clk), .rst_ni(rst_ni), .run(in_fill),
    .addr(sp_addr), .last(f_last)
  );

  nsec_status u_status (
    .clk(clk), .rst_ni(rst_ni), .run(in_done && !bus_rst),
    .slot(rd_slot), .phase(phase)
  );

  always_comb begin
    state_d = state_q;
    if (bus_rst) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_hit) state_d = wr_prot ? ST_FAIL : ST_HASH;
        ST_HASH: begin
          if (hash_done) state_d = ST_FILL;
          else if (t_expired) state_d = ST_FAIL;
        end
        ST_FILL: if (f_last) state_d = ST_DONE;
        ST_DONE: state_d = ST_DONE;
        ST_FAIL: state_d = ST_FAIL;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  assign hash_start = t_first;
  assign sec_we     = in_hash && hash_done && !bus_rst;
  assign sec_wdata  = hash_result;
  assign sp_we      = in_fill && !bus_rst;
  assign sp_wdata   = FILL_BYTE;
  assign busy       = in_hash || in_fill;
  assign rd_bit     = in_done && phase;
endmodule

// File: rtl/nsec_seq_chk.sv
module nsec_seq_chk #(
  parameter int unsigned SP_BYTES  = 8,
  parameter logic [7:0]  FILL_BYTE = 8'hAA
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_rst,
  input logic                        hash_start,
  input logic                        hash_done,
  input logic                        sec_we,
  input logic                        sp_we,
  input logic [$clog2(SP_BYTES)-1:0] sp_addr,
  input logic [7:0]                  sp_wdata,
  input logic                        rd_slot,
  input logic                        rd_bit,
  input logic                        busy
);
  localparam int unsigned AW = $clog2(SP_BYTES);

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |=> !hash_start);

  p_secwe_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_we |-> (hash_done && busy && !bus_rst));

  p_fill_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> (sp_wdata == FILL_BYTE && busy));

  p_fill_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && sp_addr != AW'(SP_BYTES - 1) && !bus_rst) |=>
      (bus_rst || (sp_we && sp_addr == $past(sp_addr) + 1'b1)));

  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_slot && !bus_rst) |=> $stable(rd_bit));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (!busy && !rd_bit));
endmodule

bind nsec_seq nsec_seq_chk #(.SP_BYTES(SP_BYTES), .FILL_BYTE(FILL_BYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .hash_start(hash_start),
  .hash_done(hash_done), .sec_we(sec_we), .sp_we(sp_we), .sp_addr(sp_addr),
  .sp_wdata(sp_wdata), .rd_slot(rd_slot), .rd_bit(rd_bit), .busy(busy)
);

// File: tb/tb_nsec_seq.sv
`timescale 1ns/1ps
module tb_nsec_seq;
  localparam int unsigned SW  = 32;
  localparam int unsigned SPB = 8;
  localparam int unsigned TMO = 12;
  localparam logic [7:0]  CMD = 8'h33;
  localparam logic [7:0]  FIL = 8'hAA;

  logic clk = 1'b0;
  logic rst_n, cmd_valid, bus_rst, wr_prot, hash_done, rd_slot;
  logic [7:0] cmd_byte;
  logic [SW-1:0] hash_result;
  logic hash_start, sec_we, sp_we, rd_bit, busy;
  logic [SW-1:0] sec_wdata;
  logic [$clog2(SPB)-1:0] sp_addr;
  logic [7:0] sp_wdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  nsec_seq #(.SECRET_W(SW), .SP_BYTES(SPB), .FILL_BYTE(FIL), .CMD_NEXT(CMD),
             .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .bus_rst(bus_rst), .wr_prot(wr_prot), .hash_start(hash_start),
    .hash_done(hash_done), .hash_result(hash_result), .sec_we(sec_we),
    .sec_wdata(sec_wdata), .sp_we(sp_we), .sp_addr(sp_addr), .sp_wdata(sp_wdata),
    .rd_slot(rd_slot), .rd_bit(rd_bit), .busy(busy)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic issue(input logic [7:0] b, input logic prot);
    cmd_valid = 1'b1; cmd_byte = b; wr_prot = prot;
    tick();
    cmd_valid = 1'b0; cmd_byte = 8'h00; wr_prot = 1'b0;
    settle();
  endtask

  task automatic bus_reset();
    bus_rst = 1'b1;
    settle();
    chk("R10 sec_we under bus_rst", {63'd0, sec_we}, 64'd0);
    chk("R10 sp_we under bus_rst", {63'd0, sp_we}, 64'd0);
    tick();
    bus_rst = 1'b0;
    settle();
    chk("R10 busy after bus_rst", {63'd0, busy}, 64'd0);
    chk("R10 rd_bit after bus_rst", {63'd0, rd_bit}, 64'd0);
  endtask

  task automatic zero_slots(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      chk(tag, {63'd0, rd_bit}, 64'd0);
      rd_slot = 1'b1; tick(); rd_slot = 1'b0; settle();
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_byte = 8'h00; bus_rst = 1'b0;
    wr_prot = 1'b0; hash_done = 1'b0; hash_result = '0; rd_slot = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    settle();
    // R1 reset state
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 hash_start", {63'd0, hash_start}, 64'd0);
    chk("R1 sec_we", {63'd0, sec_we}, 64'd0);
    chk("R1 sp_we", {63'd0, sp_we}, 64'd0);
    chk("R1 rd_bit", {63'd0, rd_bit}, 64'd0);

    // R2 every non-matching command byte is ignored
    for (int b = 0; b < 256; b++) begin
      if (b[7:0] != CMD) begin
        issue(b[7:0], 1'b0);
        chk("R2 busy on foreign byte", {63'd0, busy}, 64'd0);
        chk("R2 hash_start on foreign byte", {63'd0, hash_start}, 64'd0);
      end
    end

    // R3 write-protected refusal
    issue(CMD, 1'b1);
    chk("R3 hash_start", {63'd0, hash_start}, 64'd0);
    chk("R3 busy", {63'd0, busy}, 64'd0);
    for (int i = 0; i < 4; i++) begin
      chk("R3 sec_we", {63'd0, sec_we}, 64'd0);
      chk("R3 sp_we", {63'd0, sp_we}, 64'd0);
      tick(); settle();
    end
    zero_slots("R3 status bit", 5);
    bus_reset();

    // R4-R9 sweep of hash_done arrival over every allowed cycle
    for (int d = 0; d < int'(TMO); d++) begin
      logic [SW-1:0] val;
      val = 32'hC0DE0000 ^ (32'(d) * 32'h01010101);
      issue(CMD, 1'b0);
      for (int i = 0; i < d; i++) begin
        chk("R4 hash_start", {63'd0, hash_start}, {63'd0, (i == 0)});
        chk("R8 busy in hash", {63'd0, busy}, 64'd1);
        chk("R5 no early sec_we", {63'd0, sec_we}, 64'd0);
        tick(); settle();
      end
      hash_done = 1'b1; hash_result = val;
      settle();
      chk("R4 hash_start at done", {63'd0, hash_start}, {63'd0, (d == 0)});
      chk("R5 sec_we", {63'd0, sec_we}, 64'd1);
      chk("R5 sec_wdata", {32'd0, sec_wdata}, {32'd0, val});
      tick();
      hash_done = 1'b0; hash_result = '0;
      settle();
      for (int j = 0; j < int'(SPB); j++) begin
        chk("R7 sp_we", {63'd0, sp_we}, 64'd1);
        chk("R7 sp_addr", 64'(sp_addr), 64'(j));
        chk("R7 sp_wdata", {56'd0, sp_wdata}, {56'd0, FIL});
        chk("R8 busy in fill", {63'd0, busy}, 64'd1);
        tick(); settle();
      end
      chk("R8 busy after fill", {63'd0, busy}, 64'd0);
      chk("R7 sp_we after fill", {63'd0, sp_we}, 64'd0);
      if (d == 3) begin
        // R2 command while finished is ignored
        issue(CMD, 1'b0);
        chk("R2 busy on late command", {63'd0, busy}, 64'd0);
      end
      for (int k = 0; k < 6; k++) begin
        chk("R9 status bit", {63'd0, rd_bit}, 64'(k % 2));
        rd_slot = 1'b1; tick(); rd_slot = 1'b0; settle();
      end
      bus_reset();
    end

    // R6 timeout
    issue(CMD, 1'b0);
    for (int i = 0; i < int'(TMO); i++) begin
      chk("R6 busy while waiting", {63'd0, busy}, 64'd1);
      chk("R6 sec_we", {63'd0, sec_we}, 64'd0);
      tick(); settle();
    end
    chk("R6 busy after timeout", {63'd0, busy}, 64'd0);
    chk("R6 sp_we after timeout", {63'd0, sp_we}, 64'd0);
    hash_done = 1'b1; hash_result = 32'hFFFF0000;
    settle();
    chk("R6 late done ignored", {63'd0, sec_we}, 64'd0);
    hash_done = 1'b0;
    zero_slots("R6 status bit", 4);
    bus_reset();

    // R10 abort during hash, coinciding with done
    issue(CMD, 1'b0);
    tick(); settle();
    hash_done = 1'b1; hash_result = 32'h12345678;
    bus_reset();
    hash_done = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R10 no fill after hash abort", {63'd0, sp_we}, 64'd0);
      tick(); settle();
    end

    // R10 abort during fill
    issue(CMD, 1'b0);
    hash_done = 1'b1; hash_result = 32'hA5A5A5A5; settle();
    tick(); hash_done = 1'b0; settle();
    repeat (3) begin tick(); settle(); end
    chk("R7 mid-fill address", 64'(sp_addr), 64'd3);
    bus_reset();
    for (int i = 0; i < 4; i++) begin
      chk("R10 no fill after abort", {63'd0, sp_we}, 64'd0);
      tick(); settle();
    end
    // R2 idle again: command accepted after abort
    issue(CMD, 1'b0);
    chk("R2 restart after abort", {63'd0, hash_start}, 64'd1);
    bus_reset();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule